// File: doc/BRIEF.md
# FFT Memory Bank Scheduler

This block steers memory traffic for an in-place radix-2 block FFT that runs one pipelined butterfly per clock. Samples sit in three banks. Every sample index with an even number of set bits lives in the main bank. Every index with an odd count lives in one of two secondary banks. In both cases the entry address is the index with its least significant bit dropped. Butterfly partners differ in exactly one bit, so each butterfly has one operand in the main bank and one in a secondary bank. Within a stage, one secondary bank is only read and the other is only written. The two swap roles at every stage boundary.

After a start pulse the scheduler walks the log2(N) stages in order. In each stage it issues N/2 butterfly reads, one per cycle, together with the per-stage scale flag. It then waits a drain gap of one pipeline length, so that the next stage never reads a location that the previous stage has not yet written back. Each write address is the matching read address delayed through a pipeline that models the butterfly latency. While the scheduler is idle or finished, it also gives two address decodes. The load decode places an incoming sample, optionally at its bit-reversed index. The output decode turns a natural-order index into a bank and an address, so a reader does not need to know the bank layout.

Top module: `fft_bank_sched`

## Requirements
- R1: During and right after reset, `busy`, `done`, `rd_en`, `wr_en` and `ld_we` are all 0.
- R2: A `start` pulse seen while idle or finished starts a run, and `busy` rises in the next cycle. Stage s (0 to LOG2N-1) holds `rd_en` high for N/2 consecutive cycles, followed by PIPE cycles with `rd_en` low. Stage 0 begins in the first cycle after `start` is sampled.
- R3: In cycle k of stage s, the lower operand index is the k-th integer with bit s clear, and the upper index is that integer plus 2^s. Over a stage, every index is read exactly once.
- R4: Index i is placed in bank code 0 (main) when its count of set bits is even, and in a secondary bank otherwise. Its address is i >> 1. Port A always carries the even-count operand and port B the odd-count one. `rd_swap` is 1 exactly when port A holds the upper index.
- R5: Bank codes are 0 for main, 1 for secondary 0 and 2 for secondary 1. An even stage reads port B from code 1 and writes port B to code 2. An odd stage does the reverse.
- R6: `wr_en`, `wr_addr_a` and `wr_addr_b` repeat `rd_en`, `rd_addr_a` and `rd_addr_b` exactly PIPE cycles later. `wr_bank_b` is the write bank of the stage that issued the read.
- R7: In no cycle does any bank get two reads or two writes. The secondary bank being written is never the one being read in the same cycle.
- R8: `rd_scale` during stage s equals bit s of `scale_sched` as sampled with the accepted `start`. Later changes to `scale_sched` have no effect on the run.
- R9: `done` rises in the first cycle after the final write of the last stage, which is LOG2N*(N/2+PIPE) cycles after the first read cycle. `busy` is low while `done` is high. `done` stays high until the next accepted `start`.
- R10: While not busy, `ld_we` follows `load_valid`. The target index is `load_idx`, or its bit reversal over LOG2N bits when `load_bitrev` is 1. `ld_bank` and `ld_addr` follow R4, with odd-count indices placed in code 1.
- R11: While `busy` is high, `ld_we` stays 0 whatever the value of `load_valid`.
- R12: A `start` pulse while busy is ignored, and the read and write sequence continues unchanged.
- R13: For `out_idx`, `out_addr` is out_idx >> 1. `out_bank` is 0 for an even bit count. For an odd count it is 1 when LOG2N is even and 2 when LOG2N is odd, which is the bank written by the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a transform |
| scale_sched | input | LOG2N | One scale bit per stage, captured at start |
| load_valid | input | 1 | A sample is offered for loading |
| load_bitrev | input | 1 | Place the load at the bit-reversed index |
| load_idx | input | LOG2N | Index of the offered sample |
| out_idx | input | LOG2N | Natural-order index to decode after completion |
| busy | output | 1 | Stages or drain gaps in progress |
| done | output | 1 | Transform complete, data readable |
| rd_en | output | 1 | Butterfly read issued this cycle |
| rd_addr_a | output | LOG2N-1 | Main-bank read address (even-count operand) |
| rd_addr_b | output | LOG2N-1 | Secondary-bank read address (odd-count operand) |
| rd_bank_b | output | 2 | Bank code for the port B read |
| rd_swap | output | 1 | Port A holds the upper butterfly index |
| rd_scale | output | 1 | Scale flag for this butterfly |
| wr_en | output | 1 | Butterfly result write this cycle |
| wr_addr_a | output | LOG2N-1 | Main-bank write address |
| wr_addr_b | output | LOG2N-1 | Secondary-bank write address |
| wr_bank_b | output | 2 | Bank code for the port B write |
| ld_we | output | 1 | Load write enable |
| ld_bank | output | 2 | Bank code for the load write |
| ld_addr | output | LOG2N-1 | Address for the load write |
| out_bank | output | 2 | Bank code holding `out_idx` |
| out_addr | output | LOG2N-1 | Address holding `out_idx` |

## Verification
The assertions check on every clock that the port B read and write always target a secondary bank and never the same one. They also check that the read bank holds steady inside a stage, that loads are blocked while busy, that a run only begins after `start`, and that `done` follows a write and then holds. The exact pair order, the address and swap values, the delayed write stream, the scale capture, the completion cycle count and both decodes are only shown by the bench. Its per-cycle reference model compares them over two full transforms that use different schedules and include ignored `start` and load pulses.

// File: rtl/fftsch_pkg.sv
package fftsch_pkg;
  localparam int MAXW = 16;

  typedef logic [MAXW-1:0] idx_t;

  typedef enum logic [1:0] {
    BANK_MAIN = 2'd0,
    BANK_SEC0 = 2'd1,
    BANK_SEC1 = 2'd2
  } bank_e;

  // Reverse the lowest w bits of x.
  function automatic idx_t bit_reverse(idx_t x, int unsigned w);
    idx_t r;
    r = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < int'(w)) r[int'(w) - 1 - i] = x[i];
    end
    return r;
  endfunction

  // Open a zero bit at position s inside pair counter p.
  function automatic idx_t open_slot(idx_t p, int unsigned s);
    idx_t low_mask;
    low_mask = (idx_t'(1) << s) - idx_t'(1);
    return ((p >> s) << (s + 1)) | (p & low_mask);
  endfunction

  // Odd count of set bits.
  function automatic logic odd_weight(idx_t x);
    return ^x;
  endfunction

  function automatic bank_e sec_bank(logic sel);
    return sel ? BANK_SEC1 : BANK_SEC0;
  endfunction
endpackage

// File: rtl/fftsch_seq.sv
module fftsch_seq #(
  parameter int LOG2N = 10,
  parameter int PIPE  = 8,
  parameter int SW    = $clog2(LOG2N),
  parameter int AW    = LOG2N - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LOG2N-1:0] sched_in,
  output logic             issue,
  output logic [SW-1:0]    stage,
  output logic [AW-1:0]    pair,
  output logic             scale,
  output logic             busy,
  output logic             done,
  output logic             launch,
  output logic             stage_end
);
  localparam int DW = $clog2(PIPE + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_FIN} st_e;

  st_e              state;
  logic [DW-1:0]    dcnt;
  logic [LOG2N-1:0] sched_q;
  logic             pair_last, drain_last, stage_last;

  assign pair_last  = &pair;
  assign drain_last = (dcnt == DW'(PIPE - 1));
  assign stage_last = (stage == SW'(LOG2N - 1));
  assign launch     = start && (state == S_IDLE || state == S_FIN);
  assign stage_end  = (state == S_DRAIN) && drain_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stage   <= '0;
      pair    <= '0;
      dcnt    <= '0;
      sched_q <= '0;
    end else begin
      case (state)
        S_IDLE, S_FIN: begin
          if (start) begin
            state   <= S_RUN;
            stage   <= '0;
            pair    <= '0;
            sched_q <= sched_in;
          end
        end
        S_RUN: begin
          pair <= pair + 1'b1;
          if (pair_last) begin
            state <= S_DRAIN;
            dcnt  <= '0;
          end
        end
        S_DRAIN: begin
          dcnt <= dcnt + 1'b1;
          if (drain_last) begin
            dcnt <= '0;
            if (stage_last) begin
              state <= S_FIN;
            end else begin
              stage <= stage + 1'b1;
              state <= S_RUN;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign issue = (state == S_RUN);
  assign busy  = (state == S_RUN) || (state == S_DRAIN);
  assign done  = (state == S_FIN);
  assign scale = sched_q[stage];
endmodule

// File: rtl/fftsch_pairmap.sv
module fftsch_pairmap
  import fftsch_pkg::*;
#(
  parameter int LOG2N = 10,
  parameter int SW    = $clog2(LOG2N),
  parameter int AW    = LOG2N - 1
) (
  input  logic [SW-1:0] stage,
  input  logic [AW-1:0] pair,
  output logic [AW-1:0] addr_even,
  output logic [AW-1:0] addr_odd,
  output logic          swap,
  output bank_e         rd_sec,
  output bank_e         wr_sec
);
  idx_t lo, hi, ev, od;
  logic lo_odd;

  always_comb begin
    lo     = open_slot(idx_t'(pair), 32'(stage));
    hi     = lo | (idx_t'(1) << stage);
    lo_odd = odd_weight(lo);
    ev     = lo_odd ? hi : lo;
    od     = lo_odd ? lo : hi;
  end

  assign addr_even = ev[AW:1];
  assign addr_odd  = od[AW:1];
  assign swap      = lo_odd;
  assign rd_sec    = sec_bank(stage[0]);
  assign wr_sec    = sec_bank(~stage[0]);
endmodule

// File: rtl/fftsch_delay.sv
module fftsch_delay #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign dout = pipe_q[DEPTH-1];
endmodule

// File: rtl/fftsch_place.sv
module fftsch_place
  import fftsch_pkg::*;
#(
  parameter int LOG2N = 10,
  parameter int AW    = LOG2N - 1
) (
  input  logic [LOG2N-1:0] idx,
  input  logic             reverse,
  input  bank_e            sec,
  output logic [1:0]       bank,
  output logic [AW-1:0]    addr
);
  idx_t pos;

  always_comb begin
    pos = reverse ? bit_reverse(idx_t'(idx), LOG2N) : idx_t'(idx);
  end

  assign bank = odd_weight(pos) ? sec : BANK_MAIN;
  assign addr = pos[AW:1];
endmodule

// File: rtl/fft_bank_sched.sv
module fft_bank_sched
  import fftsch_pkg::*;
#(
  parameter int LOG2N = 10,
  parameter int PIPE  = 8,
  localparam int AW   = LOG2N - 1,
  localparam int SW   = $clog2(LOG2N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LOG2N-1:0] scale_sched,
  input  logic             load_valid,
  input  logic             load_bitrev,
  input  logic [LOG2N-1:0] load_idx,
  input  logic [LOG2N-1:0] out_idx,
  output logic             busy,
  output logic             done,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr_a,
  output logic [AW-1:0]    rd_addr_b,
  output logic [1:0]       rd_bank_b,
  output logic             rd_swap,
  output logic             rd_scale,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr_a,
  output logic [AW-1:0]    wr_addr_b,
  output logic [1:0]       wr_bank_b,
  output logic             ld_we,
  output logic [1:0]       ld_bank,
  output logic [AW-1:0]    ld_addr,
  output logic [1:0]       out_bank,
  output logic [AW-1:0]    out_addr
);
  localparam int    DLW       = 1 + 2 * AW + 2;
  localparam bank_e FINAL_SEC = (LOG2N % 2 == 1) ? BANK_SEC1 : BANK_SEC0;

  logic [SW-1:0]  stage;
  logic [AW-1:0]  pair;
  logic           launch, stage_end;
  bank_e          rd_sec, wr_sec;
  logic [DLW-1:0] wr_in, wr_out;

  fftsch_seq #(.LOG2N(LOG2N), .PIPE(PIPE), .SW(SW), .AW(AW)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sched_in(scale_sched),
    .issue(rd_en), .stage(stage), .pair(pair), .scale(rd_scale),
    .busy(busy), .done(done), .launch(launch), .stage_end(stage_end)
  );

  fftsch_pairmap #(.LOG2N(LOG2N), .SW(SW), .AW(AW)) i_map (
    .stage(stage), .pair(pair), .addr_even(rd_addr_a), .addr_odd(rd_addr_b),
    .swap(rd_swap), .rd_sec(rd_sec), .wr_sec(wr_sec)
  );

  assign rd_bank_b = rd_sec;
  assign wr_in     = {rd_en, rd_addr_a, rd_addr_b, logic'(wr_sec[1]), logic'(wr_sec[0])};

  fftsch_delay #(.DEPTH(PIPE), .W(DLW)) i_dly (
    .clk(clk), .rst_n(rst_n), .din(wr_in), .dout(wr_out)
  );

  assign {wr_en, wr_addr_a, wr_addr_b, wr_bank_b} = wr_out;

  assign ld_we = load_valid && !busy;

  fftsch_place #(.LOG2N(LOG2N), .AW(AW)) i_ld_place (
    .idx(load_idx), .reverse(load_bitrev), .sec(BANK_SEC0),
    .bank(ld_bank), .addr(ld_addr)
  );

  fftsch_place #(.LOG2N(LOG2N), .AW(AW)) i_out_place (
    .idx(out_idx), .reverse(1'b0), .sec(FINAL_SEC),
    .bank(out_bank), .addr(out_addr)
  );
endmodule

// File: rtl/fft_bank_sched_chk.sv
module fft_bank_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       launch,
  input logic       stage_end,
  input logic       busy,
  input logic       done,
  input logic       rd_en,
  input logic [1:0] rd_bank_b,
  input logic       wr_en,
  input logic [1:0] wr_bank_b,
  input logic       ld_we
);
  // R2: a run begins only after a start pulse
  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R2: no reads outside a run
  a_r2_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en);

  // R7: port B reads a secondary bank
  a_r7_rd_b_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_bank_b == 2'd1 || rd_bank_b == 2'd2));

  // R7: port B writes a secondary bank
  a_r7_wr_b_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_bank_b == 2'd1 || wr_bank_b == 2'd2));

  // R7: never read and write the same secondary bank in one cycle
  a_r7_split_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> (rd_bank_b != wr_bank_b));

  // R5: read bank stays fixed within a run of reads
  a_r5_stage_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> $stable(rd_bank_b));

  // R9: completion follows a write and excludes busy
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(wr_en) && $past(stage_end)));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rd_en));

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !launch) |=> done);

  // R11: no load writes while busy
  a_r11_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_we);
endmodule

bind fft_bank_sched fft_bank_sched_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .launch(launch), .stage_end(stage_end),
  .busy(busy), .done(done), .rd_en(rd_en), .rd_bank_b(rd_bank_b),
  .wr_en(wr_en), .wr_bank_b(wr_bank_b), .ld_we(ld_we)
);

// File: tb/test_fft_bank_sched.sv
module test_fft_bank_sched;
  localparam int CLK_PERIOD = 10;
  localparam int LOG2N = 10;
  localparam int PIPE  = 8;
  localparam int N     = 1 << LOG2N;
  localparam int HALF  = N / 2;
  localparam int AW    = LOG2N - 1;
  localparam int SLEN  = HALF + PIPE;
  localparam int TOTAL = LOG2N * SLEN;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LOG2N-1:0] scale_sched = '0;
  logic             load_valid = 1'b0;
  logic             load_bitrev = 1'b0;
  logic [LOG2N-1:0] load_idx = '0;
  logic [LOG2N-1:0] out_idx = '0;
  logic             busy, done, rd_en, rd_swap, rd_scale, wr_en, ld_we;
  logic [AW-1:0]    rd_addr_a, rd_addr_b, wr_addr_a, wr_addr_b, ld_addr, out_addr;
  logic [1:0]       rd_bank_b, wr_bank_b, ld_bank, out_bank;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fft_bank_sched #(.LOG2N(LOG2N), .PIPE(PIPE)) i_fft_bank_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .scale_sched(scale_sched),
    .load_valid(load_valid), .load_bitrev(load_bitrev), .load_idx(load_idx),
    .out_idx(out_idx), .busy(busy), .done(done), .rd_en(rd_en),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_bank_b(rd_bank_b),
    .rd_swap(rd_swap), .rd_scale(rd_scale), .wr_en(wr_en),
    .wr_addr_a(wr_addr_a), .wr_addr_b(wr_addr_b), .wr_bank_b(wr_bank_b),
    .ld_we(ld_we), .ld_bank(ld_bank), .ld_addr(ld_addr),
    .out_bank(out_bank), .out_addr(out_addr)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int parity_of(int x);
    return $countones(x) % 2;
  endfunction

  function automatic int reversed(int x);
    int r = 0;
    for (int b = 0; b < LOG2N; b++) r = r * 2 + ((x >> b) & 1);
    return r;
  endfunction

  // Expected read operands for pair k of stage s
  task automatic expect_pair(input int s, input int k, output int ea, output int eb, output int esw);
    int lo, hi, ev;
    lo  = (k / (1 << s)) * (2 << s) + k % (1 << s);
    hi  = lo + (1 << s);
    ev  = (parity_of(lo) == 0) ? lo : hi;
    esw = (ev == hi) ? 1 : 0;
    ea  = ev / 2;
    eb  = ((ev == lo) ? hi : lo) / 2;
  endtask

  task automatic run_fft(input logic [LOG2N-1:0] sched, input bit poke);
    bit seen [N];
    int s, k, ea, eb, esw, ia, ib, c2;
    bit exp_rd, exp_wr;
    @(negedge clk);
    start = 1'b1;
    scale_sched = sched;
    for (int c = 0; c < TOTAL + 4; c++) begin
      @(negedge clk);
      if (c == 0) begin
        start = 1'b0;
        scale_sched = ~sched;   // R8: later changes ignored
      end
      s = c / SLEN;
      k = c % SLEN;
      exp_rd = (s < LOG2N) && (k < HALF);
      chk(busy == (c < TOTAL), "R2", "busy", int'(busy), int'(c < TOTAL));
      chk(done == (c >= TOTAL), "R9", "done", int'(done), int'(c >= TOTAL));
      chk(rd_en == exp_rd, "R2", "rd_en", int'(rd_en), int'(exp_rd));
      if (exp_rd) begin
        if (k == 0) foreach (seen[j]) seen[j] = 1'b0;
        expect_pair(s, k, ea, eb, esw);
        chk(int'(rd_addr_a) == ea, "R4", "rd_addr_a", int'(rd_addr_a), ea);
        chk(int'(rd_addr_b) == eb, "R4", "rd_addr_b", int'(rd_addr_b), eb);
        chk(int'(rd_swap) == esw, "R4", "rd_swap", int'(rd_swap), esw);
        chk(int'(rd_bank_b) == ((s % 2 == 0) ? 1 : 2), "R5", "rd_bank_b", int'(rd_bank_b), (s % 2 == 0) ? 1 : 2);
        chk(rd_scale == sched[s], "R8", "rd_scale", int'(rd_scale), int'(sched[s]));
        ia = int'(rd_addr_a) * 2 + parity_of(int'(rd_addr_a));
        ib = int'(rd_addr_b) * 2 + 1 - parity_of(int'(rd_addr_b));
        chk((ia ^ ib) == (1 << s) && !seen[ia] && !seen[ib], "R3", "partner", ia ^ ib, 1 << s);
        seen[ia] = 1'b1;
        seen[ib] = 1'b1;
      end
      c2 = c - PIPE;
      exp_wr = (c2 >= 0) && (c2 / SLEN < LOG2N) && (c2 % SLEN < HALF);
      chk(wr_en == exp_wr, "R6", "wr_en", int'(wr_en), int'(exp_wr));
      if (exp_wr) begin
        expect_pair(c2 / SLEN, c2 % SLEN, ea, eb, esw);
        chk(int'(wr_addr_a) == ea, "R6", "wr_addr_a", int'(wr_addr_a), ea);
        chk(int'(wr_addr_b) == eb, "R6", "wr_addr_b", int'(wr_addr_b), eb);
        chk(int'(wr_bank_b) == (((c2 / SLEN) % 2 == 0) ? 2 : 1), "R5", "wr_bank_b",
            int'(wr_bank_b), ((c2 / SLEN) % 2 == 0) ? 2 : 1);
      end
      if (poke) begin
        if (c == 40) start = 1'b1;        // R12: ignored while busy
        if (c == 41) start = 1'b0;
        if (c == 60) begin                // R11: load blocked while busy
          load_valid = 1'b1;
          #1;
          chk(ld_we == 1'b0, "R11", "ld_we", int'(ld_we), 0);
          load_valid = 1'b0;
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ld_list [6] = '{0, 1, 3, N - 1, 341, 672};
    int pos;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en && !ld_we, "R1", "in reset",
        int'({busy, done, rd_en, wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en, "R1", "after reset",
        int'({busy, done, rd_en, wr_en}), 0);

    // R10: load decode, natural and bit-reversed
    foreach (ld_list[i]) begin
      for (int rv = 0; rv < 2; rv++) begin
        load_idx = LOG2N'(ld_list[i]);
        load_bitrev = rv[0];
        load_valid = 1'b1;
        #1;
        pos = (rv == 1) ? reversed(ld_list[i]) : ld_list[i];
        chk(ld_we == 1'b1, "R10", "ld_we", int'(ld_we), 1);
        chk(int'(ld_bank) == parity_of(pos), "R10", "ld_bank", int'(ld_bank), parity_of(pos));
        chk(int'(ld_addr) == pos / 2, "R10", "ld_addr", int'(ld_addr), pos / 2);
        @(negedge clk);
      end
    end
    load_valid = 1'b0;

    // R13: output decode
    foreach (ld_list[i]) begin
      out_idx = LOG2N'(ld_list[i]);
      #1;
      pos = (parity_of(ld_list[i]) == 0) ? 0 : ((LOG2N % 2 == 0) ? 1 : 2);
      chk(int'(out_bank) == pos, "R13", "out_bank", int'(out_bank), pos);
      chk(int'(out_addr) == ld_list[i] / 2, "R13", "out_addr", int'(out_addr), ld_list[i] / 2);
      @(negedge clk);
    end

    run_fft(10'h2AB, 1'b1);
    run_fft(10'h0F3, 1'b0);   // R9: restart from finished state

    load_valid = 1'b1;
    load_idx = 10'd5;
    load_bitrev = 1'b0;
    #1;
    chk(ld_we == 1'b1, "R10", "ld_we when done", int'(ld_we), 1);
    load_valid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule